// File: doc/BRIEF.md
# Multicore Private Region Register Decoder

This block sits behind a simple register bus and covers the 8 KB private window of a small processor cluster. The lowest 256 bytes hold a handful of snoop-control registers that live in the block itself: an enable bit, a read-only configuration word derived from the core count, two words that read as zero, and an error status word. The rest of the window is split into select strobes for the devices that sit behind it. These are the interrupt CPU interfaces, one timer and one watchdog per core, and the interrupt distributor.

Each banked device has a "current core" alias followed by one copy per present core. Core numbers at or above the core count select nothing. When a strobe is raised, the block also gives the offset inside that sub-region on a local address output. The selected device then answers the access itself. Accesses that land in the control block or in a hole are answered by this block with a one-cycle ready pulse. Any access to a hole sets a sticky error flag.

Top module: `privwin_decode`

## Requirements
- R1: Byte offset 0x00 holds a control register in which only bit 0 is stored. Bits 31..1 always read as zero. A synchronous reset clears the register to zero.
- R2: A read of offset 0x04 returns the core count minus one in bits [1:0]. It also returns a mask with one bit per present core starting at bit 4. With two cores the word is 0x31.
- R3: Offsets 0x08 and 0x0C read as zero. Writes to 0x04, 0x08 and 0x0C change no register.
- R4: An access to an undefined offset inside the first 0x100 bytes, or to any hole in the window, reads as zero and changes no register.
- R5: An access that raises no select strobe gets rsp_ready high for exactly the following cycle, with rsp_rdata valid in that cycle. An access that raises a strobe gets no ready from this block.
- R6: sel_cif_cur is high for 0x100..0x1FF. sel_cif_core[k] is high for 0x200+k*0x100 .. 0x2FF+k*0x100, for each k below the core count.
- R7: sel_tmr_cur is high for 0x600..0x61F and sel_wdg_cur for 0x620..0x63F. For core k, sel_tmr_core[k] is high for 0x700+k*0x100 .. +0x1F, and sel_wdg_core[k] for the next 0x20 bytes.
- R8: sel_dist is high for 0x1000..0x1FFF.
- R9: At most one strobe is high at a time. An alias for a core at or above the core count raises no strobe.
- R10: Offset 0x10 bit 0 reads a sticky error flag, which is set by every R4 access. Writing 1 to that bit clears the flag, and writing 0 leaves it unchanged.
- R11: loc_addr carries the address bits [11:0] for the distributor, bits [7:0] for a CPU interface, and bits [4:0] for a timer or watchdog, with the upper bits zero. It is zero when no strobe is high.
- R12: With req_valid low, no strobe is raised and loc_addr is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Access request, one cycle per access |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | 13 | Byte offset in the private window |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data for locally answered accesses |
| rsp_ready | output | 1 | Completion pulse for locally answered accesses |
| sel_cif_cur | output | 1 | Current-core interrupt CPU interface strobe |
| sel_cif_core | output | NCORE | Per-core interrupt CPU interface strobes |
| sel_tmr_cur | output | 1 | Current-core timer strobe |
| sel_tmr_core | output | NCORE | Per-core timer strobes |
| sel_wdg_cur | output | 1 | Current-core watchdog strobe |
| sel_wdg_core | output | NCORE | Per-core watchdog strobes |
| sel_dist | output | 1 | Interrupt distributor strobe |
| loc_addr | output | 12 | Offset inside the selected sub-region |

## Verification
The assertions assume that reset is held for at least one clock before any access. They also assume that req_valid is a plain per-cycle request, with req_addr and req_wr stable while it is high. The ready and read-data properties are stated against the request seen one cycle earlier, so they assume that no reset falls between a request and its response. The stimulus keeps to this by making one access per two cycles, with idle cycles in between. Reset is raised only between accesses.

// File: rtl/privwin_decode.sv
module privwin_decode #(
  parameter int NCORE = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic             req_wr,
  input  logic [12:0]      req_addr,
  input  logic [31:0]      req_wdata,
  output logic [31:0]      rsp_rdata,
  output logic             rsp_ready,
  output logic             sel_cif_cur,
  output logic [NCORE-1:0] sel_cif_core,
  output logic             sel_tmr_cur,
  output logic [NCORE-1:0] sel_tmr_core,
  output logic             sel_wdg_cur,
  output logic [NCORE-1:0] sel_wdg_core,
  output logic             sel_dist,
  output logic [11:0]      loc_addr
);
  localparam logic [31:0] CFG_WORD = 32'((((1 << NCORE) - 1) << 4) | (NCORE - 1));
  localparam logic [5:0]  W_CTL = 6'd0, W_CFG = 6'd1, W_ERR = 6'd4;

  logic       ctl_q, err_q;
  wire  [4:0] page = req_addr[12:8];
  wire  [7:0] pofs = req_addr[7:0];
  wire  [5:0] word = req_addr[7:2];
  wire        unused_ok = ^{req_wdata[31:1], req_addr[1:0]};

  assign sel_cif_cur = req_valid && page == 5'd1;
  assign sel_tmr_cur = req_valid && page == 5'd6 && pofs[7:5] == 3'd0;
  assign sel_wdg_cur = req_valid && page == 5'd6 && pofs[7:5] == 3'd1;
  assign sel_dist    = req_valid && req_addr[12];

  for (genvar k = 0; k < NCORE; k++) begin : g_core
    assign sel_cif_core[k] = req_valid && page == 5'(2 + k);
    assign sel_tmr_core[k] = req_valid && page == 5'(7 + k) && pofs[7:5] == 3'd0;
    assign sel_wdg_core[k] = req_valid && page == 5'(7 + k) && pofs[7:5] == 3'd1;
  end

  wire any_cif = sel_cif_cur || (|sel_cif_core);
  wire any_tw  = sel_tmr_cur || sel_wdg_cur || (|sel_tmr_core) || (|sel_wdg_core);
  wire loc_acc = req_valid && !(any_cif || any_tw || sel_dist);
  wire known   = page == 5'd0 && word <= W_ERR;
  wire undef   = loc_acc && !known;
  wire wr_reg  = loc_acc && known && req_wr;

  assign loc_addr = sel_dist ? req_addr[11:0] :
                    any_cif  ? {4'd0, pofs} :
                    any_tw   ? {7'd0, pofs[4:0]} : 12'd0;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q     <= 1'b0;
      err_q     <= 1'b0;
      rsp_ready <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_ready <= loc_acc;
      rsp_rdata <= '0;
      if (loc_acc && known && !req_wr) begin
        case (word)
          W_CTL:   rsp_rdata <= {31'd0, ctl_q};
          W_CFG:   rsp_rdata <= CFG_WORD;
          W_ERR:   rsp_rdata <= {31'd0, err_q};
          default: rsp_rdata <= '0;
        endcase
      end
      if (wr_reg && word == W_CTL) ctl_q <= req_wdata[0];
      if (undef) err_q <= 1'b1;
      else if (wr_reg && word == W_ERR && req_wdata[0]) err_q <= 1'b0;
    end
  end
endmodule

// File: rtl/privwin_decode_chk.sv
module privwin_decode_chk #(
  parameter int NCORE = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic             req_wr,
  input logic [12:0]      req_addr,
  input logic [31:0]      req_wdata,
  input logic [31:0]      rsp_rdata,
  input logic             rsp_ready,
  input logic             sel_cif_cur,
  input logic [NCORE-1:0] sel_cif_core,
  input logic             sel_tmr_cur,
  input logic [NCORE-1:0] sel_tmr_core,
  input logic             sel_wdg_cur,
  input logic [NCORE-1:0] sel_wdg_core,
  input logic             sel_dist,
  input logic [11:0]      loc_addr,
  input logic             err_q
);
  localparam logic [31:0] CFG_EXP = 32'((((1 << NCORE) - 1) << 4) | (NCORE - 1));
  wire [3*NCORE+3:0] sels = {sel_dist, sel_wdg_core, sel_wdg_cur, sel_tmr_core,
                             sel_tmr_cur, sel_cif_core, sel_cif_cur};

  assert_sel_onehot_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sels));
  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (rst)
    !req_valid |-> (sels == '0 && loc_addr == 12'd0));
  assert_ready_cause_R5: assert property (@(posedge clk) disable iff (rst)
    rsp_ready |-> $past(req_valid));
  assert_fwd_silent_R5: assert property (@(posedge clk) disable iff (rst)
    (req_valid && sels != '0) |=> !rsp_ready);
  assert_cfg_read_R2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_wr && req_addr == 13'h004) |=> rsp_rdata == CFG_EXP);
  assert_ctl_upper_zero_R1: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_wr && req_addr[12:2] == 11'd0) |=> rsp_rdata[31:1] == 31'd0);
  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    ($past(err_q) && !$past(req_valid && req_wr && req_addr[12:2] == 11'd4 && req_wdata[0]))
      |-> err_q);
endmodule

bind privwin_decode privwin_decode_chk #(.NCORE(NCORE)) chk_i (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_wr(req_wr), .req_addr(req_addr),
  .req_wdata(req_wdata), .rsp_rdata(rsp_rdata), .rsp_ready(rsp_ready),
  .sel_cif_cur(sel_cif_cur), .sel_cif_core(sel_cif_core), .sel_tmr_cur(sel_tmr_cur),
  .sel_tmr_core(sel_tmr_core), .sel_wdg_cur(sel_wdg_cur), .sel_wdg_core(sel_wdg_core),
  .sel_dist(sel_dist), .loc_addr(loc_addr), .err_q(err_q)
);

// File: tb/privwin_decode_tb.sv
`timescale 1ns/100ps
module privwin_decode_tb_top;
  localparam int N  = 2;
  localparam int SW = 3 * N + 4;

  logic clk = 0, rst = 1, req_valid = 0, req_wr = 0;
  logic [12:0] req_addr = '0;
  logic [31:0] req_wdata = '0, rsp_rdata;
  logic rsp_ready, sel_cif_cur, sel_tmr_cur, sel_wdg_cur, sel_dist;
  logic [N-1:0] sel_cif_core, sel_tmr_core, sel_wdg_core;
  logic [11:0] loc_addr;

  int n_chk = 0, n_fail = 0;
  bit m_ctl = 0, m_err = 0;

  always #2.5 clk = ~clk;

  privwin_decode #(.NCORE(N)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_wr(req_wr), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_rdata(rsp_rdata), .rsp_ready(rsp_ready),
    .sel_cif_cur(sel_cif_cur), .sel_cif_core(sel_cif_core), .sel_tmr_cur(sel_tmr_cur),
    .sel_tmr_core(sel_tmr_core), .sel_wdg_cur(sel_wdg_cur), .sel_wdg_core(sel_wdg_core),
    .sel_dist(sel_dist), .loc_addr(loc_addr));

  wire [SW-1:0] selv = {sel_dist, sel_wdg_core, sel_wdg_cur, sel_tmr_core,
                        sel_tmr_cur, sel_cif_core, sel_cif_cur};

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [SW-1:0] exp_sel(input int a);
    logic [SW-1:0] v = '0;
    int o = a % 256;
    if (a >= 'h1000) v[3*N+3] = 1;
    else if (a >= 'h100 && a < 'h200) v[0] = 1;
    else if (a >= 'h200 && a < 'h200 + N * 256) v[1 + (a - 'h200) / 256] = 1;
    else if (a >= 'h600 && a < 'h700) begin
      if (o < 32) v[N + 1] = 1;
      else if (o < 64) v[2 * N + 2] = 1;
    end else if (a >= 'h700 && a < 'h700 + N * 256) begin
      if (o < 32) v[N + 2 + (a - 'h700) / 256] = 1;
      else if (o < 64) v[2 * N + 3 + (a - 'h700) / 256] = 1;
    end
    return v;
  endfunction

  function automatic logic [11:0] exp_loc(input int a);
    logic [SW-1:0] v = exp_sel(a);
    if (v == '0) return 12'd0;
    if (a >= 'h1000) return 12'(a % 4096);
    if (a < 'h600) return 12'(a % 256);
    return 12'(a % 32);
  endfunction

  task automatic acc(input bit wr, input int a, input logic [31:0] wd, input string tag);
    logic [SW-1:0] es;
    logic [31:0] er;
    bit loc, known;
    int w = a / 4;
    @(negedge clk);
    chk(rsp_ready == 1'b0, "R5 idle", 32'(rsp_ready), 0);
    req_valid = 1; req_wr = wr; req_addr = 13'(a); req_wdata = wd;
    #1;
    es = exp_sel(a);
    chk(selv == es, {tag, " sel"}, 32'(selv), 32'(es));
    chk(loc_addr == exp_loc(a), "R11 loc_addr", 32'(loc_addr), 32'(exp_loc(a)));
    loc = (es == '0);
    known = (a < 'h100) && (w <= 4);
    er = 0;
    if (loc && known && !wr) begin
      if (w == 0) er = 32'(m_ctl);
      else if (w == 1) er = 32'(((1 << N) - 1) * 16 + N - 1);
      else if (w == 4) er = 32'(m_err);
    end
    if (loc && known && wr && w == 0) m_ctl = wd[0];
    if (loc && !known) m_err = 1;
    else if (loc && known && wr && w == 4 && wd[0]) m_err = 0;
    @(negedge clk);
    req_valid = 0; req_wr = 0;
    #1;
    chk(rsp_ready == loc, "R5 ready", 32'(rsp_ready), 32'(loc));
    if (loc && !wr) chk(rsp_rdata == er, {tag, " rdata"}, rsp_rdata, er);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1;
    @(negedge clk); @(negedge clk); rst = 0;
    m_ctl = 0; m_err = 0;
    #1;
    chk(rsp_ready == 0 && rsp_rdata == 0, "R1 reset outputs", {rsp_rdata[30:0], rsp_ready}, 0);
  endtask

  initial begin
    #(200000 * 5);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    do_reset();
    chk(selv == '0 && loc_addr == 0, "R12 idle selects", 32'(selv), 0);
    acc(0, 'h000, 0, "R1");
    acc(0, 'h010, 0, "R10");
    acc(0, 'h004, 0, "R2");
    acc(1, 'h000, 32'hFFFF_FFFF, "R1");
    acc(0, 'h000, 0, "R1");
    acc(1, 'h004, 32'h0, "R3");
    acc(1, 'h008, 32'h0, "R3");
    acc(1, 'h00C, 32'h0, "R3");
    acc(0, 'h000, 0, "R3");
    acc(0, 'h004, 0, "R3");
    acc(0, 'h008, 0, "R3");
    acc(0, 'h00C, 0, "R3");
    acc(0, 'h020, 0, "R4");
    acc(0, 'h010, 0, "R10");
    acc(1, 'h010, 32'h0, "R10");
    acc(0, 'h010, 0, "R10");
    acc(1, 'h010, 32'h1, "R10");
    acc(0, 'h010, 0, "R10");
    acc(1, 'h040, 32'h0, "R4");
    acc(1, 'h0FC, 32'h0, "R4");
    acc(0, 'h000, 0, "R4");
    acc(1, 'h000, 32'h2, "R1");
    acc(0, 'h000, 0, "R1");
    acc(0, 'h100, 0, "R6");
    acc(1, 'h204, 32'h5, "R6");
    acc(0, 'h3FC, 0, "R6");
    acc(0, 'h400, 0, "R9");
    acc(0, 'h5FC, 0, "R9");
    acc(0, 'h610, 0, "R7");
    acc(0, 'h624, 0, "R7");
    acc(0, 'h640, 0, "R4");
    acc(0, 'h704, 0, "R7");
    acc(1, 'h73C, 32'h1, "R7");
    acc(0, 'h81F, 0, "R7");
    acc(0, 'h820, 0, "R7");
    acc(0, 'h904, 0, "R9");
    acc(0, 'hB00, 0, "R4");
    acc(0, 'h1000, 0, "R8");
    acc(1, 'h1ABC, 32'h7, "R8");
    acc(0, 'h1FFF, 0, "R8");
    acc(0, 'h010, 0, "R10");
    acc(1, 'h000, 32'h1, "R1");
    do_reset();
    acc(0, 'h000, 0, "R1");
    acc(0, 'h010, 0, "R10");
    @(negedge clk); #1;
    chk(selv == '0 && loc_addr == 0, "R12 idle selects", 32'(selv), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule